// File: doc/BRIEF.md
# Flash Bus Mode Output Decoder

This block decides, from the control pins of a parallel NOR flash device, what the device shows on its data pins and on its ready/busy pin during a read. It works as a purely combinational decoder. It turns power-down, two active-low chip enables, output enable, write enable and the byte/word select into a drive decision. Each data pin gets its own output-enable bit, so the pad ring or a bench can see high impedance directly. It does not hold the array and does not decode commands. The surrounding logic supplies the array word, the status byte, a per-sector protection mask, and flags that say whether status mode is active and whether the write engine is busy or suspended.

The data source follows a fixed priority. The identifier flag stands for the high-voltage level on the ninth address pin and wins over everything else. When it is set, the two lowest word address bits pick one of three codes: the maker code, a device code set by parameter, or a protection flag for the sector named by the top four word address bits. Below that comes status mode, and the array word comes last.

In byte mode the top data pin becomes an extra low address input. The upper data pins are then left floating. That extra address bit picks the array byte lane, while identifier and status bytes always appear on the low lane.

Top module: `flashBusDecoder`

## Requirements
- R1: While `pwdN` is 0, every bit of `dataOe` is 0 and `rdyLevel` is 1, whatever the other inputs are.
- R2: If `ce1N` or `ce2N` is 1, every bit of `dataOe` is 0 (standby).
- R3: Data is driven only when the device is selected, `oeN` is 0 and `weN` is 1. If `oeN` is 1 or `weN` is 0, all of `dataOe` is 0.
- R4: With `idMode`=1 and `addrLow`=2'b00, the driven value is 16'h00C2 in word mode. This holds even when `statusSel` is 1.
- R5: With `idMode`=1 and `addrLow`=2'b01, the driven value is {8'h00, DEV_CODE}, where DEV_CODE is 8'hFA by default.
- R6: With `idMode`=1 and `addrLow`=2'b10, the driven value is 16'h0001 if `protectMask[sectorAddr]` is 1, and 16'h0000 otherwise. With `addrLow`=2'b11 it is 16'h0000.
- R7: In byte mode (`byteN`=0) with array data, `aMinus1`=0 puts `arrayData[7:0]` on bits 7:0, and `aMinus1`=1 puts `arrayData[15:8]` there. `dataOe[15:8]` is 0.
- R8: `rdyLevel` is 0 exactly when `pwdN`=1, `wsmBusy`=1 and `eraseSuspended`=0. It does not depend on `oeN`, `ce1N` or `ce2N`.
- R9: With `statusSel`=1 and `idMode`=0, the driven value is {8'h00, statusData[7:2], 2'b00}.
- R10: In byte mode, identifier and status bytes appear on bits 7:0 whatever the value of `aMinus1`, and `dataOe[15:8]` is 0.
- R11: In word mode, a driven read sets all 16 bits of `dataOe` and places the 16-bit word on `dataOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pwdN | input | 1 | Deep power-down, active low |
| ce1N | input | 1 | First chip enable, active low |
| ce2N | input | 1 | Second chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| byteN | input | 1 | 0 selects byte mode, 1 selects word mode |
| aMinus1 | input | 1 | Byte-lane address taken from the top data pin in byte mode |
| addrLow | input | 2 | Word address bits 1:0 |
| sectorAddr | input | 4 | Top word address bits naming the sector |
| idMode | input | 1 | Identifier read flag (high voltage on address pin 9) |
| statusSel | input | 1 | Status read mode is active |
| arrayData | input | 16 | Array word at the current address |
| statusData | input | 8 | Status byte from the write engine |
| protectMask | input | 16 | One protection bit per sector |
| wsmBusy | input | 1 | Write engine is running an operation |
| eraseSuspended | input | 1 | Erase is suspended |
| dataOut | output | 16 | Value for the data pins |
| dataOe | output | 16 | Per-pin drive enable |
| rdyLevel | output | 1 | Ready/busy pin level: 0 means pulled low |

## Verification
Every output is combinational, so a wrong internal decision shows at the ports as soon as the inputs settle. A wrong select term makes the whole `dataOe` vector go high when it should stay 0, or stay 0 when it should go high. A wrong source choice puts the array word where a code belongs. A wrong lane bit makes the two halves of the array word appear swapped in byte mode. The vectors therefore pair each control pin with one neighbour that differs only in that pin. They also use array, status and code values whose two bytes are distinct, so that a swapped lane or a missed mask cannot go unseen.

// File: rtl/flashBusPkg.sv
package flashBusPkg;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_ID     = 2'd2
  } srcSelT;

  typedef struct packed {
    logic   drive;     // read cycle in progress, pins may be driven
    logic   byteMode;  // upper lane floats
    logic   hiLane;    // byte lane pick for array data
    srcSelT src;       // which word reaches the pins
  } busCtrlT;

endpackage

// File: rtl/flashBusCtrl.sv
module flashBusCtrl
  import flashBusPkg::*;
(
  input  logic    pwdN,
  input  logic    ce1N,
  input  logic    ce2N,
  input  logic    oeN,
  input  logic    weN,
  input  logic    byteN,
  input  logic    aMinus1,
  input  logic    idMode,
  input  logic    statusSel,
  input  logic    wsmBusy,
  input  logic    eraseSuspended,
  output busCtrlT ctrl,
  output logic    rdyLevel
);

  logic selected;

  always_comb begin
    selected      = pwdN & ~ce1N & ~ce2N;
    ctrl.drive    = selected & ~oeN & weN;
    ctrl.byteMode = ~byteN;
    ctrl.hiLane   = ~byteN & aMinus1;
    if (idMode)         ctrl.src = SRC_ID;
    else if (statusSel) ctrl.src = SRC_STATUS;
    else                ctrl.src = SRC_ARRAY;
    // open-drain pin: pulled low only while an operation actually runs
    rdyLevel = ~(pwdN & wsmBusy & ~eraseSuspended);
  end

endmodule

// File: rtl/flashBusDatapath.sv
module flashBusDatapath
  import flashBusPkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          SECTORS  = 16,
  parameter logic [7:0]  MFR_CODE = 8'hC2,
  parameter logic [7:0]  DEV_CODE = 8'hFA,
  localparam int         BYTE_W   = DATA_W / 2,
  localparam int         SECT_AW  = $clog2(SECTORS)
) (
  input  busCtrlT             ctrl,
  input  logic [1:0]          addrLow,
  input  logic [SECT_AW-1:0]  sectorAddr,
  input  logic [DATA_W-1:0]   arrayData,
  input  logic [BYTE_W-1:0]   statusData,
  input  logic [SECTORS-1:0]  protectMask,
  output logic [DATA_W-1:0]   dataOut,
  output logic [DATA_W-1:0]   dataOe
);

  logic [BYTE_W-1:0] idByte;
  logic [DATA_W-1:0] srcWord;
  logic [BYTE_W-1:0] lowByte;

  always_comb begin
    unique case (addrLow)
      2'b00:   idByte = MFR_CODE;
      2'b01:   idByte = DEV_CODE;
      2'b10:   idByte = {{(BYTE_W-1){1'b0}}, protectMask[sectorAddr]};
      default: idByte = '0;
    endcase
  end

  always_comb begin
    unique case (ctrl.src)
      SRC_ID:     srcWord = {{BYTE_W{1'b0}}, idByte};
      SRC_STATUS: srcWord = {{BYTE_W{1'b0}}, statusData[BYTE_W-1:2], 2'b00};
      default:    srcWord = arrayData;
    endcase
  end

  always_comb begin
    // lane pick applies to array words only; codes always sit low
    if (ctrl.hiLane && ctrl.src == SRC_ARRAY) lowByte = srcWord[DATA_W-1:BYTE_W];
    else                                      lowByte = srcWord[BYTE_W-1:0];
    if (ctrl.byteMode) dataOut = {{BYTE_W{1'b0}}, lowByte};
    else               dataOut = srcWord;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_pinOe
    if (i < BYTE_W) begin : g_low
      assign dataOe[i] = ctrl.drive;
    end else begin : g_high
      assign dataOe[i] = ctrl.drive & ~ctrl.byteMode;
    end
  end

endmodule

// File: rtl/flashBusDecoder.sv
module flashBusDecoder
  import flashBusPkg::*;
#(
  parameter logic [7:0] DEV_CODE = 8'hFA
) (
  input  logic        pwdN,
  input  logic        ce1N,
  input  logic        ce2N,
  input  logic        oeN,
  input  logic        weN,
  input  logic        byteN,
  input  logic        aMinus1,
  input  logic [1:0]  addrLow,
  input  logic [3:0]  sectorAddr,
  input  logic        idMode,
  input  logic        statusSel,
  input  logic [15:0] arrayData,
  input  logic [7:0]  statusData,
  input  logic [15:0] protectMask,
  input  logic        wsmBusy,
  input  logic        eraseSuspended,
  output logic [15:0] dataOut,
  output logic [15:0] dataOe,
  output logic        rdyLevel
);

  busCtrlT ctrl;

  flashBusCtrl i_ctrl (
    .pwdN(pwdN), .ce1N(ce1N), .ce2N(ce2N), .oeN(oeN), .weN(weN),
    .byteN(byteN), .aMinus1(aMinus1), .idMode(idMode), .statusSel(statusSel),
    .wsmBusy(wsmBusy), .eraseSuspended(eraseSuspended),
    .ctrl(ctrl), .rdyLevel(rdyLevel)
  );

  flashBusDatapath #(
    .DATA_W(16), .SECTORS(16), .MFR_CODE(8'hC2), .DEV_CODE(DEV_CODE)
  ) i_dp (
    .ctrl(ctrl), .addrLow(addrLow), .sectorAddr(sectorAddr),
    .arrayData(arrayData), .statusData(statusData), .protectMask(protectMask),
    .dataOut(dataOut), .dataOe(dataOe)
  );

endmodule

// File: rtl/flashBusChecker.sv
module flashBusChecker #(
  parameter logic [7:0] DEV_CODE = 8'hFA
) (
  input logic        pwdN,
  input logic        ce1N,
  input logic        ce2N,
  input logic        oeN,
  input logic        weN,
  input logic        byteN,
  input logic [1:0]  addrLow,
  input logic        idMode,
  input logic        wsmBusy,
  input logic        eraseSuspended,
  input logic [15:0] dataOut,
  input logic [15:0] dataOe,
  input logic        rdyLevel
);

  logic readCycle;
  assign readCycle = pwdN & ~ce1N & ~ce2N & ~oeN & weN;

  always_comb begin
    if (!pwdN) begin
      p_pwd_quiet_r1: assert (dataOe == 16'h0 && rdyLevel);
    end
    if (ce1N || ce2N) begin
      p_standby_float_r2: assert (dataOe == 16'h0);
    end
    if (oeN || !weN) begin
      p_no_read_float_r3: assert (dataOe == 16'h0);
    end
    if (readCycle && byteN && idMode && addrLow == 2'b00) begin
      p_maker_code_r4: assert (dataOut == 16'h00C2);
    end
    if (readCycle && byteN && idMode && addrLow == 2'b01) begin
      p_device_code_r5: assert (dataOut == {8'h00, DEV_CODE});
    end
    if (!byteN) begin
      p_upper_lane_float_r7: assert (dataOe[15:8] == 8'h00);
    end
    p_busy_level_r8: assert (rdyLevel == !(pwdN && wsmBusy && !eraseSuspended));
    if (readCycle && byteN) begin
      p_word_drive_r11: assert (dataOe == 16'hFFFF);
    end
  end

endmodule

bind flashBusDecoder flashBusChecker #(.DEV_CODE(DEV_CODE)) i_chk (
  .pwdN(pwdN), .ce1N(ce1N), .ce2N(ce2N), .oeN(oeN), .weN(weN),
  .byteN(byteN), .addrLow(addrLow), .idMode(idMode),
  .wsmBusy(wsmBusy), .eraseSuspended(eraseSuspended),
  .dataOut(dataOut), .dataOe(dataOe), .rdyLevel(rdyLevel)
);

// File: tb/test_flashBusDecoder.sv
module test_flashBusDecoder;

  typedef struct packed {
    logic        pwdN, ce1N, ce2N, oeN, weN, byteN, aMinus1, idMode, statusSel;
    logic [1:0]  addr;
    logic [3:0]  sect;
    logic [15:0] expOe;
    logic [15:0] expOut;
    logic [7:0]  req;
  } vecT;

  localparam int NVEC = 18;
  // arrayData A55A, statusData B7 -> B4, protectMask 8421 (sectors 0,5,10,15)
  localparam vecT VECS [NVEC] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,4'd0,16'h0000,16'h0000,8'd1},  // R1 power-down
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,4'd0,16'h0000,16'h0000,8'd2},  // R2 ce1 high
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,4'd0,16'h0000,16'h0000,8'd2},  // R2 ce2 high
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,4'd0,16'h0000,16'h0000,8'd3},  // R3 oe high
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,4'd0,16'h0000,16'h0000,8'd3},  // R3 write cycle
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,4'd0,16'hFFFF,16'hA55A,8'd11}, // R11 word read
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,4'd0,16'h00FF,16'h005A,8'd7},  // R7 low lane
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,4'd0,16'h00FF,16'h00A5,8'd7},  // R7 high lane
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,4'd0,16'hFFFF,16'h00C2,8'd4},  // R4 maker
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,2'b00,4'd0,16'hFFFF,16'h00C2,8'd4},  // R4 id beats status
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,2'b01,4'd0,16'hFFFF,16'h00FA,8'd5},  // R5 device
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,2'b10,4'd5,16'hFFFF,16'h0001,8'd6},  // R6 protected
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,2'b10,4'd6,16'hFFFF,16'h0000,8'd6},  // R6 open sector
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,2'b11,4'd5,16'hFFFF,16'h0000,8'd6},  // R6 unused code
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,2'b00,4'd0,16'hFFFF,16'h00B4,8'd9},  // R9 status word
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,2'b00,4'd0,16'h00FF,16'h00B4,8'd10}, // R10 status byte
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,4'd0,16'h00FF,16'h00C2,8'd10}, // R10 id byte
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00,4'd0,16'h0000,16'h0000,8'd1}   // R1 beats id
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic pwdN, ce1N, ce2N, oeN, weN, byteN, aMinus1, idMode, statusSel;
  logic [1:0]  addrLow;
  logic [3:0]  sectorAddr;
  logic [15:0] arrayData, protectMask;
  logic [7:0]  statusData;
  logic        wsmBusy, eraseSuspended;
  logic [15:0] dataOut, dataOe;
  logic        rdyLevel;

  int checks = 0;
  int errors = 0;

  flashBusDecoder i_flashBusDecoder (
    .pwdN(pwdN), .ce1N(ce1N), .ce2N(ce2N), .oeN(oeN), .weN(weN),
    .byteN(byteN), .aMinus1(aMinus1), .addrLow(addrLow), .sectorAddr(sectorAddr),
    .idMode(idMode), .statusSel(statusSel), .arrayData(arrayData),
    .statusData(statusData), .protectMask(protectMask), .wsmBusy(wsmBusy),
    .eraseSuspended(eraseSuspended), .dataOut(dataOut), .dataOe(dataOe),
    .rdyLevel(rdyLevel)
  );

  task automatic checkBus(input string tag, input logic [15:0] expOe, input logic [15:0] expOut);
    checks++;
    if (dataOe !== expOe || (dataOut & dataOe) !== expOut) begin
      errors++;
      $display("FAIL %s oe=%h out=%h expected oe=%h out=%h", tag, dataOe, dataOut & dataOe, expOe, expOut);
    end
  endtask

  task automatic checkRdy(input string tag, input logic exp);
    checks++;
    if (rdyLevel !== exp) begin
      errors++;
      $display("FAIL %s rdyLevel=%b expected %b", tag, rdyLevel, exp);
    end
  endtask

  initial begin
    pwdN = 1'b0; ce1N = 1'b0; ce2N = 1'b0; oeN = 1'b0; weN = 1'b1;
    byteN = 1'b1; aMinus1 = 1'b0; idMode = 1'b0; statusSel = 1'b0;
    addrLow = 2'b00; sectorAddr = 4'd0;
    arrayData = 16'hA55A; statusData = 8'hB7; protectMask = 16'h8421;
    wsmBusy = 1'b1; eraseSuspended = 1'b0;
    @(negedge clk);
    // R1: powered down at start, with the engine busy
    checkBus("R1 start", 16'h0000, 16'h0000);
    checkRdy("R1 start", 1'b1);
    wsmBusy = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {pwdN, ce1N, ce2N, oeN, weN, byteN, aMinus1, idMode, statusSel} =
        {VECS[i].pwdN, VECS[i].ce1N, VECS[i].ce2N, VECS[i].oeN, VECS[i].weN,
         VECS[i].byteN, VECS[i].aMinus1, VECS[i].idMode, VECS[i].statusSel};
      addrLow = VECS[i].addr;
      sectorAddr = VECS[i].sect;
      #2;
      checkBus($sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].expOe, VECS[i].expOut);
    end

    // R8: ready/busy level under directed patterns
    @(negedge clk);
    pwdN = 1'b1; ce1N = 1'b0; ce2N = 1'b0; oeN = 1'b0; weN = 1'b1; idMode = 1'b0; statusSel = 1'b0;
    wsmBusy = 1'b0; eraseSuspended = 1'b0; #2;
    checkRdy("R8 idle", 1'b1);
    wsmBusy = 1'b1; #2;
    checkRdy("R8 busy", 1'b0);
    oeN = 1'b1; ce1N = 1'b1; #2;
    checkRdy("R8 busy deselected", 1'b0);
    eraseSuspended = 1'b1; #2;
    checkRdy("R8 suspended", 1'b1);
    eraseSuspended = 1'b0; pwdN = 1'b0; #2;
    checkRdy("R1 busy in power-down", 1'b1);

    // R7 with a different array word, and R6 on the last sector
    @(negedge clk);
    pwdN = 1'b1; ce1N = 1'b0; oeN = 1'b0; wsmBusy = 1'b0;
    arrayData = 16'h3C81; byteN = 1'b0; aMinus1 = 1'b1; #2;
    checkBus("R7 second word high lane", 16'h00FF, 16'h003C);
    byteN = 1'b1; idMode = 1'b1; addrLow = 2'b10; sectorAddr = 4'd15; #2;
    checkBus("R6 sector 15", 16'hFFFF, 16'h0001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule